// File: doc/BRIEF.md
# Inverter Gate Protection Sequencer

This block sits between a motor-control PWM generator and the gate drivers of a three-phase inverter bridge. Each phase has a high-side and a low-side command, both active high. The block passes each command to its gate output. It blanks gates when a protection condition is present and drives an active-low fault line that a controller can poll or take as an interrupt.

There are three kinds of fault, and each one acts on the gates, reports on the fault line and recovers in its own way.

- **Low-side short circuit.** All low-side gates are cut at once. The fault line gives a pulse of fixed length.
- **Low-side supply undervoltage.** All low-side gates are cut. The fault line stays low for at least the same pulse length, and for as long as the supply stays below its release level. Trip and release come in as separate indications, which gives hysteresis.
- **High-side supply undervoltage on one phase.** Only that phase's high-side gate is cut. The fault line does not report it.

After any fault, a gate drives again only after its own command shows a new low-to-high transition.

Top module: `gate_prot_seq`

## Requirements
- R1: Reset forces every gate output low and `fault_n` high. The previous-command register resets to all ones. So a command that is already high when reset ends does not drive its gate until it has been sampled low and then high.
- R2: When a phase is armed and no fault blocks it, each gate output equals its command input in the same cycle.
- R3: While `sc_det` is high, all low-side gate outputs are low in the same cycle, and the high-side outputs are unaffected.
- R4: A `sc_det` sampled high at a clock edge pulls `fault_n` low from that edge. `fault_n` stays low for exactly `PULSE_CYC` cycles.
- R5: When a low-side fault ends, each low-side gate stays low until its own command is sampled low at one edge and high at the next. Each phase re-arms on its own.
- R6: A `sc_det` or `lo_uv_trip` that arrives while the fault pulse is running reloads the full `PULSE_CYC` count.
- R7: While `lo_uv_trip` is high, all low-side gates are low in the same cycle, and `fault_n` goes low from the next edge.
- R8: After a low-side undervoltage trip, `fault_n` stays low while the undervoltage state holds and for at least `PULSE_CYC` cycles. Only `lo_uv_clear` ends the undervoltage state.
- R9: When `lo_uv_trip` and `lo_uv_clear` are high in the same cycle, the trip wins and the undervoltage state is entered.
- R10: A high `hi_uv[i]` forces only `hi_gate[i]` low in the same cycle. `fault_n` and all other gates are unaffected.
- R11: After `hi_uv[i]` drops, `hi_gate[i]` stays low until a new rising edge of `hi_cmd[i]`.
- R12: A command rising edge that arrives while its phase is blocked does not re-arm that phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hi_cmd | input | PHASES | High-side gate commands, active high |
| lo_cmd | input | PHASES | Low-side gate commands, active high |
| sc_det | input | 1 | Short-circuit comparator flag |
| lo_uv_trip | input | 1 | Low-side supply below trip level |
| lo_uv_clear | input | 1 | Low-side supply above release level |
| hi_uv | input | PHASES | Per-phase high-side supply undervoltage |
| hi_gate | output | PHASES | Gated high-side drives |
| lo_gate | output | PHASES | Gated low-side drives |
| fault_n | output | 1 | Active-low fault indication |

## Verification
The bench targets re-arming after a fault. A command held high through a fault, or one that toggles while the fault is still running, must not bring its gate back. A design that re-armed on level, or took edges during blanking, would drive a low-side gate straight after the pulse.

It also checks the pulse length at the exact cycle, restarts of the timer in mid-pulse, and a release of the undervoltage state that comes before the minimum width has passed. An off-by-one counter, or a release that cut the pulse short, would lift `fault_n` a cycle early.

Finally it drives trip and release together and applies a high-side undervoltage alone. A design with the wrong priority would leave `fault_n` high, and a design that reported the high-side fault would pull it low.

// File: rtl/gps_pkg.sv
package gps_pkg;
   typedef enum logic {
      SUPPLY_OK  = 1'b0,
      SUPPLY_LOW = 1'b1
   } supply_e;

   typedef struct packed {
      logic sc;
      logic trip;
      logic clr;
   } lo_flags_t;
endpackage

// File: rtl/gps_edge_arm.sv
module gps_edge_arm #(
   parameter int N = 3
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] cmd,
   input  logic [N-1:0] block,
   output logic [N-1:0] gate
);
   if (N < 1) begin : g_bad_n
      $error("gps_edge_arm: N must be at least 1");
   end

   logic [N-1:0] cmd_q;
   logic [N-1:0] arm_q;

   for (genvar i = 0; i < N; i++) begin : g_ph
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            cmd_q[i] <= 1'b1;
            arm_q[i] <= 1'b0;
         end else begin
            cmd_q[i] <= cmd[i];
            if (block[i])
               arm_q[i] <= 1'b0;
            else if (cmd[i] && !cmd_q[i])
               arm_q[i] <= 1'b1;
         end
      end

      assign gate[i] = cmd[i] & arm_q[i] & ~block[i];

      // R5, R11, R12: a cycle under blanking leaves the phase disarmed
      a_r12_blocked_then_off : assert property (@(posedge clk) disable iff (!rst_n)
         block[i] |=> !gate[i]);

      a_r2_gate_needs_cmd : assert property (@(posedge clk) disable iff (!rst_n)
         $rose(gate[i]) |-> cmd[i]);
   end
endmodule

// File: rtl/gps_pulse_timer.sv
module gps_pulse_timer #(
   parameter int PULSE_CYC = 240000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   output logic busy
);
   localparam int CNT_W = $clog2(PULSE_CYC + 1);
   localparam logic [CNT_W-1:0] LOAD = CNT_W'(PULSE_CYC);

   if (PULSE_CYC < 1) begin : g_bad_len
      $error("gps_pulse_timer: PULSE_CYC must be at least 1");
   end

   logic [CNT_W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt <= '0;
      else if (start)
         cnt <= LOAD;
      else if (cnt != '0)
         cnt <= cnt - 1'b1;
   end

   assign busy = (cnt != '0);

   a_r6_restart_full : assert property (@(posedge clk) disable iff (!rst_n)
      start |=> (cnt == LOAD));

   a_r4_countdown : assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !start) |=> (cnt == $past(cnt) - 1'b1));
endmodule

// File: rtl/gps_lo_supply.sv
module gps_lo_supply
   import gps_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic trip,
   input  logic clr,
   output logic low
);
   supply_e st;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         st <= SUPPLY_OK;
      else if (trip)
         st <= SUPPLY_LOW;
      else if (clr)
         st <= SUPPLY_OK;
   end

   assign low = (st == SUPPLY_LOW);

   a_r9_trip_wins : assert property (@(posedge clk) disable iff (!rst_n)
      trip |=> low);

   a_r8_only_clear_releases : assert property (@(posedge clk) disable iff (!rst_n)
      (low && !clr) |=> low);
endmodule

// File: rtl/gate_prot_seq.sv
module gate_prot_seq
   import gps_pkg::*;
#(
   parameter int PHASES    = 3,
   parameter int PULSE_CYC = 240000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [PHASES-1:0] hi_cmd,
   input  logic [PHASES-1:0] lo_cmd,
   input  logic              sc_det,
   input  logic              lo_uv_trip,
   input  logic              lo_uv_clear,
   input  logic [PHASES-1:0] hi_uv,
   output logic [PHASES-1:0] hi_gate,
   output logic [PHASES-1:0] lo_gate,
   output logic              fault_n
);
   if (PHASES < 1) begin : g_bad_phases
      $error("gate_prot_seq: PHASES must be at least 1");
   end

   lo_flags_t          lf;
   logic               uv_low;
   logic               pulse_busy;
   logic               lo_kill;
   logic [PHASES-1:0]  lo_block;

   assign lf = '{sc: sc_det, trip: lo_uv_trip, clr: lo_uv_clear};

   gps_lo_supply u_supply (
      .clk   (clk),
      .rst_n (rst_n),
      .trip  (lf.trip),
      .clr   (lf.clr),
      .low   (uv_low)
   );

   gps_pulse_timer #(.PULSE_CYC(PULSE_CYC)) u_timer (
      .clk   (clk),
      .rst_n (rst_n),
      .start (lf.sc | lf.trip),
      .busy  (pulse_busy)
   );

   assign lo_kill  = lf.sc | lf.trip | uv_low | pulse_busy;
   assign lo_block = {PHASES{lo_kill}};

   gps_edge_arm #(.N(PHASES)) u_lo_arm (
      .clk   (clk),
      .rst_n (rst_n),
      .cmd   (lo_cmd),
      .block (lo_block),
      .gate  (lo_gate)
   );

   gps_edge_arm #(.N(PHASES)) u_hi_arm (
      .clk   (clk),
      .rst_n (rst_n),
      .cmd   (hi_cmd),
      .block (hi_uv),
      .gate  (hi_gate)
   );

   assign fault_n = ~(pulse_busy | uv_low);

   a_r3_sc_blanks_low : assert property (@(posedge clk) disable iff (!rst_n)
      sc_det |-> (lo_gate == '0));

   a_r7_trip_blanks_low : assert property (@(posedge clk) disable iff (!rst_n)
      lo_uv_trip |-> (lo_gate == '0));

   // R4 and R7: a short circuit or a trip pulls the fault line low at the next edge
   a_r4_event_flags_fault : assert property (@(posedge clk) disable iff (!rst_n)
      (sc_det || lo_uv_trip) |=> !fault_n);

   a_r8_low_holds_fault : assert property (@(posedge clk) disable iff (!rst_n)
      uv_low |-> !fault_n);

   a_r10_fault_source : assert property (@(posedge clk) disable iff (!rst_n)
      $fell(fault_n) |-> $past(sc_det || lo_uv_trip));

   for (genvar i = 0; i < PHASES; i++) begin : g_chk
      a_r10_hi_uv_local : assert property (@(posedge clk) disable iff (!rst_n)
         hi_uv[i] |-> !hi_gate[i]);
   end
endmodule

// File: tb/tb_gate_prot_seq.sv
module tb_gate_prot_seq;
   localparam int PH = 3;
   localparam int PW = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [PH-1:0] hi_cmd = '0, lo_cmd = '0, hi_uv = '0;
   logic          sc_det = 1'b0, lo_uv_trip = 1'b0, lo_uv_clear = 1'b0;
   logic [PH-1:0] hi_gate, lo_gate;
   logic          fault_n;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   typedef struct {
      logic [PH-1:0] h;
      logic [PH-1:0] l;
      logic          f;
      string         tag;
   } exp_t;

   exp_t q[$];

   always #5 clk = ~clk;

   gate_prot_seq #(.PHASES(PH), .PULSE_CYC(PW)) dut (
      .clk(clk), .rst_n(rst_n), .hi_cmd(hi_cmd), .lo_cmd(lo_cmd),
      .sc_det(sc_det), .lo_uv_trip(lo_uv_trip), .lo_uv_clear(lo_uv_clear),
      .hi_uv(hi_uv), .hi_gate(hi_gate), .lo_gate(lo_gate), .fault_n(fault_n)
   );

   // monitor: one expected item per clock edge
   always @(posedge clk) begin
      #2;
      if (q.size() > 0) begin
         exp_t e;
         e = q.pop_front();
         checks++;
         if (hi_gate !== e.h || lo_gate !== e.l || fault_n !== e.f) begin
            fails++;
            $display("FAIL %s: hi=%b lo=%b f=%b expected hi=%b lo=%b f=%b",
                     e.tag, hi_gate, lo_gate, fault_n, e.h, e.l, e.f);
         end
      end
   end

   task automatic drv(input logic [PH-1:0] hc, input logic [PH-1:0] lc,
                      input logic s, input logic t, input logic c,
                      input logic [PH-1:0] hu,
                      input logic [PH-1:0] eh, input logic [PH-1:0] el,
                      input logic ef, input string tag);
      exp_t e;
      @(negedge clk);
      hi_cmd = hc; lo_cmd = lc; sc_det = s; lo_uv_trip = t;
      lo_uv_clear = c; hi_uv = hu;
      e.h = eh; e.l = el; e.f = ef; e.tag = tag;
      q.push_back(e);
   endtask

   task automatic summary();
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog: run hung, actual=timeout expected=completion");
         summary();
         $finish;
      end
   end

   initial begin
      // R1: reset with commands high
      drv(3'b111, 3'b111, 0, 0, 0, 3'b000, 3'b000, 3'b000, 1, "R1 in reset");
      drv(3'b111, 3'b111, 0, 0, 0, 3'b000, 3'b000, 3'b000, 1, "R1 in reset");
      @(negedge clk);
      rst_n = 1'b1;
      drv(3'b111, 3'b111, 0, 0, 0, 3'b000, 3'b000, 3'b000, 1, "R1 held cmd no drive");
      drv(3'b000, 3'b000, 0, 0, 0, 3'b000, 3'b000, 3'b000, 1, "R1 idle");
      // R2: arm and follow
      drv(3'b111, 3'b111, 0, 0, 0, 3'b000, 3'b111, 3'b111, 1, "R2 arm");
      drv(3'b101, 3'b010, 0, 0, 0, 3'b000, 3'b101, 3'b010, 1, "R2 follow");
      drv(3'b111, 3'b111, 0, 0, 0, 3'b000, 3'b111, 3'b111, 1, "R2 follow");
      // R3 / R4: short circuit pulse
      drv(3'b111, 3'b111, 1, 0, 0, 3'b000, 3'b111, 3'b000, 0, "R3 sc blank");
      for (int j = 1; j < PW; j++)
         drv(3'b111, 3'b111, 0, 0, 0, 3'b000, 3'b111, 3'b000, 0, "R4 pulse low");
      drv(3'b111, 3'b111, 0, 0, 0, 3'b000, 3'b111, 3'b000, 1, "R4 pulse end R5 no rearm");
      // R5: per-phase re-arm
      drv(3'b111, 3'b000, 0, 0, 0, 3'b000, 3'b111, 3'b000, 1, "R5 cmd low");
      drv(3'b111, 3'b001, 0, 0, 0, 3'b000, 3'b111, 3'b001, 1, "R5 phase0 rearm");
      drv(3'b111, 3'b011, 0, 0, 0, 3'b000, 3'b111, 3'b011, 1, "R5 phase1 rearm");
      drv(3'b111, 3'b111, 0, 0, 0, 3'b000, 3'b111, 3'b111, 1, "R5 phase2 rearm");
      // R6 restart, R12 edge during fault
      drv(3'b111, 3'b111, 1, 0, 0, 3'b000, 3'b111, 3'b000, 0, "R6 first sc");
      for (int j = 0; j < 3; j++)
         drv(3'b111, 3'b111, 0, 0, 0, 3'b000, 3'b111, 3'b000, 0, "R6 running");
      drv(3'b111, 3'b111, 1, 0, 0, 3'b000, 3'b111, 3'b000, 0, "R6 second sc");
      drv(3'b111, 3'b000, 0, 0, 0, 3'b000, 3'b111, 3'b000, 0, "R12 cmd low in fault");
      drv(3'b111, 3'b111, 0, 0, 0, 3'b000, 3'b111, 3'b000, 0, "R12 edge in fault");
      for (int j = 0; j < PW - 3; j++)
         drv(3'b111, 3'b111, 0, 0, 0, 3'b000, 3'b111, 3'b000, 0, "R6 restarted low");
      drv(3'b111, 3'b111, 0, 0, 0, 3'b000, 3'b111, 3'b000, 1, "R6 end R12 not armed");
      drv(3'b111, 3'b000, 0, 0, 0, 3'b000, 3'b111, 3'b000, 1, "R5 low");
      drv(3'b111, 3'b111, 0, 0, 0, 3'b000, 3'b111, 3'b111, 1, "R5 rearm");
      // R7 / R8: long undervoltage
      drv(3'b111, 3'b111, 0, 1, 0, 3'b000, 3'b111, 3'b000, 0, "R7 trip");
      for (int j = 0; j < 12; j++)
         drv(3'b111, 3'b111, 0, 0, 0, 3'b000, 3'b111, 3'b000, 0, "R8 held low");
      drv(3'b111, 3'b111, 0, 0, 1, 3'b000, 3'b111, 3'b000, 1, "R8 clear R5 no rearm");
      drv(3'b111, 3'b000, 0, 0, 0, 3'b000, 3'b111, 3'b000, 1, "R5 low");
      drv(3'b111, 3'b111, 0, 0, 0, 3'b000, 3'b111, 3'b111, 1, "R5 rearm");
      // R8: early clear still honours minimum width
      drv(3'b111, 3'b111, 0, 1, 0, 3'b000, 3'b111, 3'b000, 0, "R7 trip");
      drv(3'b111, 3'b111, 0, 0, 0, 3'b000, 3'b111, 3'b000, 0, "R8 min");
      drv(3'b111, 3'b111, 0, 0, 1, 3'b000, 3'b111, 3'b000, 0, "R8 early clear");
      for (int j = 0; j < PW - 3; j++)
         drv(3'b111, 3'b111, 0, 0, 0, 3'b000, 3'b111, 3'b000, 0, "R8 min width");
      drv(3'b111, 3'b111, 0, 0, 0, 3'b000, 3'b111, 3'b000, 1, "R8 min end");
      drv(3'b111, 3'b000, 0, 0, 0, 3'b000, 3'b111, 3'b000, 1, "R5 low");
      drv(3'b111, 3'b111, 0, 0, 0, 3'b000, 3'b111, 3'b111, 1, "R5 rearm");
      // R9: trip and clear together
      drv(3'b111, 3'b111, 0, 1, 1, 3'b000, 3'b111, 3'b000, 0, "R9 trip wins");
      for (int j = 0; j < PW + 1; j++)
         drv(3'b111, 3'b111, 0, 0, 0, 3'b000, 3'b111, 3'b000, 0, "R9 state low");
      drv(3'b111, 3'b111, 0, 0, 1, 3'b000, 3'b111, 3'b000, 1, "R9 clear");
      drv(3'b111, 3'b000, 0, 0, 0, 3'b000, 3'b111, 3'b000, 1, "R5 low");
      drv(3'b111, 3'b111, 0, 0, 0, 3'b000, 3'b111, 3'b111, 1, "R5 rearm");
      // R10 / R11: high-side undervoltage on phase 1
      drv(3'b111, 3'b111, 0, 0, 0, 3'b010, 3'b101, 3'b111, 1, "R10 local blank");
      for (int j = 0; j < 4; j++)
         drv(3'b111, 3'b111, 0, 0, 0, 3'b010, 3'b101, 3'b111, 1, "R10 no fault");
      drv(3'b111, 3'b111, 0, 0, 0, 3'b000, 3'b101, 3'b111, 1, "R11 wait edge");
      drv(3'b101, 3'b111, 0, 0, 0, 3'b000, 3'b101, 3'b111, 1, "R11 cmd low");
      drv(3'b111, 3'b111, 0, 0, 0, 3'b000, 3'b111, 3'b111, 1, "R11 rearm");
      drv(3'b010, 3'b101, 0, 0, 0, 3'b000, 3'b010, 3'b101, 1, "R2 follow");
      repeat (3) @(posedge clk);
      #3;
      done = 1'b1;
      summary();
      $finish;
   end
endmodule